// File: doc/BRIEF.md
# Flash Interrupt Status Unit

This unit keeps the interrupt register, the controller-status register and the first system-configuration register of a flash memory controller. It also drives the host interrupt pin and the ready pin. A command engine sends it single-cycle pulses when a load, program or erase finishes, when a command is not recognised, and when a load, program or erase fails. The host reads and writes the registers through a simple select/data port.

The host acknowledges an interrupt by writing a mask. Bits written as zero are cleared, and once the master bit is clear the error flags are wiped as well. While the master bit is pending, the unit refuses new command words. An accepted command is presented to the engine as a one-cycle issue pulse together with the stored command word. A synchronous warm-reset pulse puts the registers back to their restart values. The asynchronous reset input gives the power-up values.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After the asynchronous reset, the interrupt register reads 0x8080, the status register reads 0, configuration reads 0x40C0, the command register reads 0, ready is 1 and no issue pulse is present. Select codes are 0 interrupt, 1 status, 2 configuration and 3 command.
- R2: A warm-reset pulse sets the interrupt register to 0x8010, status to 0, configuration to 0x40C0, the command register to 0 and ready to 1. It overrides every other input in that cycle.
- R3: One cycle after a done pulse, the interrupt register has bit 15 set together with bit 7 for a load, bit 6 for a program or bit 5 for an erase. Other bits keep their values.
- R4: An unknown-command pulse sets interrupt bit 15 and status bit 10. A load failure sets status bits 10 and 13. A program failure sets status bits 10 and 12. An erase failure sets status bits 10 and 11.
- R5: A host write to select 0 replaces the interrupt register with its bitwise AND with the written word.
- R6: If interrupt bit 15 is zero after that AND, status bits 10 to 13 are cleared in the same cycle.
- R7: When an event pulse and an interrupt write land in the same cycle, the bits set by the event survive the clearing.
- R8: A write to select 3 while interrupt bit 15 is set changes nothing and produces no issue pulse. Otherwise the word is stored and the issue pulse is high for exactly the next cycle.
- R9: The interrupt pin equals interrupt bit 15 XOR the inverse of configuration bit 6.
- R10: Reading configuration returns the stored word with bits 4 to 0 forced to zero.
- R11: A write to select 2 stores the word, and ready takes the value of its bit 7.
- R12: The host cannot write the status register: a write to select 1 leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| warmRst | input | 1 | Synchronous warm-reset pulse |
| regWrEn | input | 1 | Host register write strobe |
| regWrSel | input | 2 | Register select for writes |
| regWrData | input | 16 | Host write data |
| regRdSel | input | 2 | Register select for reads |
| regRdData | output | 16 | Read data (combinational) |
| evLoadDone | input | 1 | Load finished pulse |
| evProgDone | input | 1 | Program finished pulse |
| evEraseDone | input | 1 | Erase finished pulse |
| evBadCmd | input | 1 | Unknown command pulse |
| evLoadFail | input | 1 | Load failure pulse |
| evProgFail | input | 1 | Program failure pulse |
| evEraseFail | input | 1 | Erase failure pulse |
| cmdIssue | output | 1 | One-cycle pulse for an accepted command |
| cmdCode | output | 16 | Last accepted command word |
| irqOut | output | 1 | Host interrupt pin |
| readyOut | output | 1 | Ready pin |

## Verification
The assertions assume that event inputs are pulses, that the warm reset is sampled synchronously, and that a failure pulse does not occur in the same cycle as an acknowledge write whose effect on the error flags is under test. The stimulus drives every input on the falling edge, one input pattern per cycle. It walks all 128 event combinations, and it checks error wiping only with its own model of the combined effect. Because of this, any overlap of events and writes that it produces is predicted, not excluded.

// File: rtl/fisu_pkg.sv
`timescale 1ns/1ps
package fisu_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 2;

  // interrupt register bit positions
  localparam int MASTER_BIT = 15;
  localparam int LOAD_BIT   = 7;
  localparam int PROG_BIT   = 6;
  localparam int ERASE_BIT  = 5;

  // status register error bit positions
  localparam int CMD_ERR_BIT   = 10;
  localparam int ERASE_ERR_BIT = 11;
  localparam int PROG_ERR_BIT  = 12;
  localparam int LOAD_ERR_BIT  = 13;

  // configuration bit positions
  localparam int CFG_POL_BIT   = 6;
  localparam int CFG_READY_BIT = 7;

  localparam logic [REG_W-1:0] ERR_MASK =
    (REG_W'(1) << CMD_ERR_BIT) | (REG_W'(1) << ERASE_ERR_BIT) |
    (REG_W'(1) << PROG_ERR_BIT) | (REG_W'(1) << LOAD_ERR_BIT);

  typedef enum logic [SEL_W-1:0] {
    SEL_INTR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_CMD  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             warm;
    logic             wrIntr;
    logic             wrCfg;
    logic             wrCmd;
    logic             acceptCmd;
    logic [REG_W-1:0] setIntr;
    logic [REG_W-1:0] setErr;
    logic [REG_W-1:0] wrData;
  } strobes_t;
endpackage

// File: rtl/fisu_ctrl.sv
`timescale 1ns/1ps
module fisu_ctrl
  import fisu_pkg::*;
(
  input  logic             warmRst,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regWrSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             evLoadDone,
  input  logic             evProgDone,
  input  logic             evEraseDone,
  input  logic             evBadCmd,
  input  logic             evLoadFail,
  input  logic             evProgFail,
  input  logic             evEraseFail,
  input  logic             intrPending,
  output strobes_t         stb
);
  logic anyDone;
  logic anyErr;

  assign anyDone = evLoadDone | evProgDone | evEraseDone | evBadCmd;
  assign anyErr  = evBadCmd | evLoadFail | evProgFail | evEraseFail;

  always_comb begin
    stb = '0;
    stb.warm   = warmRst;
    stb.wrData = regWrData;
    stb.wrIntr = regWrEn && (regSel_e'(regWrSel) == SEL_INTR);
    stb.wrCfg  = regWrEn && (regSel_e'(regWrSel) == SEL_CFG);
    stb.wrCmd  = regWrEn && (regSel_e'(regWrSel) == SEL_CMD);
    stb.acceptCmd = stb.wrCmd && !intrPending && !warmRst;

    stb.setIntr[MASTER_BIT] = anyDone;
    stb.setIntr[LOAD_BIT]   = evLoadDone;
    stb.setIntr[PROG_BIT]   = evProgDone;
    stb.setIntr[ERASE_BIT]  = evEraseDone;

    stb.setErr[CMD_ERR_BIT]   = anyErr;
    stb.setErr[LOAD_ERR_BIT]  = evLoadFail;
    stb.setErr[PROG_ERR_BIT]  = evProgFail;
    stb.setErr[ERASE_ERR_BIT] = evEraseFail;
  end
endmodule

// File: rtl/fisu_regs.sv
`timescale 1ns/1ps
module fisu_regs
  import fisu_pkg::*;
#(
  parameter logic [REG_W-1:0] COLD_INTR = 16'h8080,
  parameter logic [REG_W-1:0] WARM_INTR = 16'h8010,
  parameter logic [REG_W-1:0] CFG_RESET = 16'h40C0
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  output logic [REG_W-1:0] intrReg,
  output logic [REG_W-1:0] statReg,
  output logic [REG_W-1:0] cfgReg,
  output logic [REG_W-1:0] cmdReg,
  output logic             readyReg,
  output logic             cmdIssue,
  output logic             irqLevel
);
  logic [REG_W-1:0] maskedIntr;
  logic [REG_W-1:0] intrNext;
  logic [REG_W-1:0] statNext;
  logic             wipeErr;

  always_comb begin
    maskedIntr = stb.wrIntr ? (intrReg & stb.wrData) : intrReg;
    wipeErr    = stb.wrIntr && !maskedIntr[MASTER_BIT];
    // new events are ORed in after the clear so they win
    intrNext   = maskedIntr | stb.setIntr;
    statNext   = (wipeErr ? (statReg & ~ERR_MASK) : statReg) | stb.setErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrReg  <= COLD_INTR;
      statReg  <= '0;
      cfgReg   <= CFG_RESET;
      cmdReg   <= '0;
      readyReg <= 1'b1;
      cmdIssue <= 1'b0;
    end else if (stb.warm) begin
      intrReg  <= WARM_INTR;
      statReg  <= '0;
      cfgReg   <= CFG_RESET;
      cmdReg   <= '0;
      readyReg <= 1'b1;
      cmdIssue <= 1'b0;
    end else begin
      intrReg  <= intrNext;
      statReg  <= statNext;
      if (stb.wrCfg) begin
        cfgReg   <= stb.wrData;
        readyReg <= stb.wrData[CFG_READY_BIT];
      end
      if (stb.acceptCmd) cmdReg <= stb.wrData;
      cmdIssue <= stb.acceptCmd;
    end
  end

  assign irqLevel = intrReg[MASTER_BIT] ^ ~cfgReg[CFG_POL_BIT];

  // R2
  warm_values_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.warm |=> (intrReg == WARM_INTR) && (statReg == '0) && readyReg);

  // R3
  load_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setIntr[LOAD_BIT] && !stb.warm) |=> intrReg[MASTER_BIT] && intrReg[LOAD_BIT]);

  // R6
  err_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrIntr && !stb.wrData[MASTER_BIT] && (stb.setErr == '0) && !stb.warm)
      |=> ((statReg & ERR_MASK) == '0));

  // R8
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCmd && intrReg[MASTER_BIT] && !stb.warm) |=> !cmdIssue && $stable(cmdReg));

  // R11
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCfg && !stb.warm) |=> (readyReg == cfgReg[CFG_READY_BIT]));

  // R12
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.setErr == '0) && !stb.wrIntr && !stb.warm) |=> $stable(statReg));
endmodule

// File: rtl/flash_irq_status_unit.sv
`timescale 1ns/1ps
module flash_irq_status_unit
  import fisu_pkg::*;
#(
  parameter logic [15:0] COLD_INTR   = 16'h8080,
  parameter logic [15:0] WARM_INTR   = 16'h8010,
  parameter logic [15:0] CFG_RESET   = 16'h40C0,
  parameter logic [15:0] CFG_RD_MASK = 16'hFFE0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        warmRst,
  input  logic        regWrEn,
  input  logic [1:0]  regWrSel,
  input  logic [15:0] regWrData,
  input  logic [1:0]  regRdSel,
  output logic [15:0] regRdData,
  input  logic        evLoadDone,
  input  logic        evProgDone,
  input  logic        evEraseDone,
  input  logic        evBadCmd,
  input  logic        evLoadFail,
  input  logic        evProgFail,
  input  logic        evEraseFail,
  output logic        cmdIssue,
  output logic [15:0] cmdCode,
  output logic        irqOut,
  output logic        readyOut
);
  strobes_t         stb;
  logic [REG_W-1:0] intrReg;
  logic [REG_W-1:0] statReg;
  logic [REG_W-1:0] cfgReg;
  logic [REG_W-1:0] cmdReg;

  fisu_ctrl u_ctrl (
    .warmRst    (warmRst),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .regWrData  (regWrData),
    .evLoadDone (evLoadDone),
    .evProgDone (evProgDone),
    .evEraseDone(evEraseDone),
    .evBadCmd   (evBadCmd),
    .evLoadFail (evLoadFail),
    .evProgFail (evProgFail),
    .evEraseFail(evEraseFail),
    .intrPending(intrReg[MASTER_BIT]),
    .stb        (stb)
  );

  fisu_regs #(
    .COLD_INTR(COLD_INTR),
    .WARM_INTR(WARM_INTR),
    .CFG_RESET(CFG_RESET)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .intrReg (intrReg),
    .statReg (statReg),
    .cfgReg  (cfgReg),
    .cmdReg  (cmdReg),
    .readyReg(readyOut),
    .cmdIssue(cmdIssue),
    .irqLevel(irqOut)
  );

  always_comb begin
    case (regSel_e'(regRdSel))
      SEL_INTR: regRdData = intrReg;
      SEL_STAT: regRdData = statReg;
      SEL_CFG:  regRdData = cfgReg & CFG_RD_MASK;
      default:  regRdData = cmdReg;
    endcase
  end

  assign cmdCode = cmdReg;
endmodule

// File: tb/sim_flash_irq_status_unit.sv
`timescale 1ns/100ps
module sim_flash_irq_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        warmRst = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [1:0]  regRdSel = 2'd0;
  logic [15:0] regRdData;
  logic [6:0]  ev = 7'd0;
  logic        cmdIssue;
  logic [15:0] cmdCode;
  logic        irqOut;
  logic        readyOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // bench model
  logic [15:0] mIntr = 16'h8080;
  logic [15:0] mStat = 16'h0;
  logic [15:0] mCfg = 16'h40C0;
  logic [15:0] mCmd = 16'h0;
  logic        mReady = 1'b1;
  logic        mIssue = 1'b0;

  always #2 clk = ~clk;

  flash_irq_status_unit u0 (
    .clk(clk), .rstN(rstN), .warmRst(warmRst),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData),
    .evLoadDone(ev[0]), .evProgDone(ev[1]), .evEraseDone(ev[2]),
    .evBadCmd(ev[3]), .evLoadFail(ev[4]), .evProgFail(ev[5]), .evEraseFail(ev[6]),
    .cmdIssue(cmdIssue), .cmdCode(cmdCode), .irqOut(irqOut), .readyOut(readyOut)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [15:0] expRd [4];
    expRd[0] = mIntr;
    expRd[1] = mStat;
    expRd[2] = mCfg & 16'hFFE0;
    expRd[3] = mCmd;
    chk(tag, "irq", {15'd0, irqOut}, {15'd0, mIntr[15] ^ ~mCfg[6]});
    chk(tag, "ready", {15'd0, readyOut}, {15'd0, mReady});
    chk(tag, "issue", {15'd0, cmdIssue}, {15'd0, mIssue});
    chk(tag, "code", cmdCode, mCmd);
    for (int s = 0; s < 4; s++) begin
      regRdSel = s[1:0];
      #0.3;
      chk(tag, $sformatf("read%0d", s), regRdData, expRd[s]);
    end
  endtask

  task automatic step(input logic warm, input logic wr, input logic [1:0] sel,
                      input logic [15:0] d, input logic [6:0] e, input string tag);
    logic [15:0] masked;
    logic [15:0] setI;
    logic [15:0] setE;
    @(negedge clk);
    warmRst = warm; regWrEn = wr; regWrSel = sel; regWrData = d; ev = e;
    if (warm) begin
      mIntr = 16'h8010; mStat = 0; mCfg = 16'h40C0; mCmd = 0; mReady = 1; mIssue = 0;
    end else begin
      setI = 0; setE = 0;
      setI[15] = |e[3:0]; setI[7] = e[0]; setI[6] = e[1]; setI[5] = e[2];
      setE[10] = |e[6:3]; setE[13] = e[4]; setE[12] = e[5]; setE[11] = e[6];
      mIssue = wr && (sel == 2'd3) && !mIntr[15];
      if (mIssue) mCmd = d;
      masked = (wr && sel == 2'd0) ? (mIntr & d) : mIntr;
      if (wr && sel == 2'd0 && !masked[15]) mStat = mStat & ~16'h3C00;
      mStat = mStat | setE;
      mIntr = masked | setI;
      if (wr && sel == 2'd2) begin mCfg = d; mReady = d[7]; end
    end
    @(posedge clk);
    #0.4;
    checkAll(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 2'd0, 16'h0, 7'd0, tag);
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog act=running exp=done");
    if (!finished) begin
      $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
      $finish;
    end
  end

  initial begin
    #0.5 rstN = 1'b0;
    repeat (3) @(negedge clk);
    #0.4;
    checkAll("R1");
    rstN = 1'b1;
    idle("R1");

    // R5 R6: clear everything
    step(0, 1, 2'd0, 16'h0000, 7'd0, "R5");

    // R3 R4: every event combination, then acknowledge
    for (int e = 0; e < 128; e++) begin
      step(0, 0, 2'd0, 16'h0, e[6:0], (e < 8) ? "R3" : "R4");
      step(0, 1, 2'd0, 16'h0000, 7'd0, "R6");
    end

    // R7: events coincide with a full clear
    for (int e = 1; e < 128; e++) begin
      step(0, 1, 2'd0, 16'h0000, e[6:0], "R7");
      step(0, 1, 2'd0, 16'h0000, 7'd0, "R6");
    end

    // R5 R6: mask sweep over the implemented bits, errors present
    for (int m = 0; m < 32; m++) begin
      step(0, 0, 2'd0, 16'h0, 7'b1111111, "R4");
      step(0, 1, 2'd0, {m[4], 7'h7F, m[3], m[2], m[1], m[0], 4'hF}, 7'd0, "R5");
      step(0, 1, 2'd0, 16'h0000, 7'd0, "R6");
    end

    // R8: command gating
    step(0, 0, 2'd0, 16'h0, 7'd1, "R8");
    step(0, 1, 2'd3, 16'h00AB, 7'd0, "R8");
    idle("R8");
    step(0, 1, 2'd0, 16'h0000, 7'd0, "R8");
    step(0, 1, 2'd3, 16'h00CD, 7'd0, "R8");
    idle("R8");
    step(0, 1, 2'd3, 16'h0094, 7'd2, "R8");
    step(0, 1, 2'd3, 16'h0023, 7'd0, "R8");

    // R9 R10 R11: configuration sweep with both master states
    for (int k = 0; k < 256; k++) begin
      step(0, 1, 2'd2, 16'((k * 16'h1357) ^ (k << 8)), 7'd0, "R10");
      step(0, 0, 2'd0, 16'h0, 7'd4, "R9");
      step(0, 1, 2'd0, 16'h0000, 7'd0, "R11");
    end

    // R12: status writes ignored
    step(0, 0, 2'd0, 16'h0, 7'b1111000, "R12");
    step(0, 1, 2'd1, 16'h0000, 7'd0, "R12");
    step(0, 1, 2'd1, 16'hFFFF, 7'd0, "R12");
    step(0, 1, 2'd0, 16'h0000, 7'd0, "R12");
    step(0, 1, 2'd1, 16'hFFFF, 7'd0, "R12");

    // R2: warm reset overrides a write and events
    step(0, 1, 2'd2, 16'h0000, 7'd0, "R2");
    step(1, 1, 2'd2, 16'h0000, 7'b1111111, "R2");
    idle("R2");
    step(0, 1, 2'd0, 16'h0000, 7'd0, "R2");
    step(1, 1, 2'd3, 16'h0055, 7'd0, "R2");

    @(negedge clk);
    regWrEn = 0; warmRst = 0; ev = 0;
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule